// File: doc/BRIEF.md
# RDMA Write Message Segmenter and Packet Scheduler

This block sits between a queue of RDMA write commands and the packet injection port of a network interface. Software places commands in the queue and then rings a doorbell with the number of commands it added. Each command carries a source address, a destination address, a byte length and two flags that ask for an initiator-side and a remote-side completion notification. The block keeps a count of announced commands, pulls commands from the queue while that count is non-zero and a message slot is free, and holds up to four messages in flight at the same time.

On each free output beat it visits the active messages in round-robin order and cuts exactly one packet from the message it visits. A packet carries at most 2048 payload bytes. The block reports the packet's source and destination addresses, its payload size and its length in 128-byte flits, including one header flit. After each packet the message's addresses move forward by the bytes just sent. A long transfer therefore gives up the output after every packet, and a short message queued behind it completes within a few beats. The notification flags are sent only with the final beat of a message. A message of zero bytes produces a single beat that carries no data and only its notification.

Top module: `rdma_seg_top`

## Requirements
- R1: After reset, `pkt_valid` and `cmd_ready` are low and the announced-command count is zero.
- R2: `cmd_ready` is high only while the announced-command count is non-zero and a message slot is free. Each accepted command lowers the count by one. No command is taken while the count is zero.
- R3: A message is cut into packets of exactly 2048 payload bytes until 2048 or fewer bytes remain. Those remaining bytes form the final packet.
- R4: `pkt_flits` equals the payload bytes divided by 128, rounded up, plus one header flit.
- R5: The first packet of a message carries the command's addresses. Each later packet has both addresses advanced by the payload of the packet before it.
- R6: Active messages are served one packet per turn in rising slot order, wrapping around, starting after the slot served last. After reset the search starts at slot 0. A command is loaded into the lowest free slot.
- R7: `pkt_ntf_init` and `pkt_ntf_rem` copy the command's flags on the last beat of a message (`pkt_last` = 1) and are 0 on every other beat.
- R8: A zero-length command yields one beat with `pkt_bytes` = 0, `pkt_flits` = 0 and `pkt_last` = 1.
- R9: While `pkt_valid` is high and `pkt_ready` is low, every packet output holds its value.
- R10: At most four messages are active. With all slots busy, `cmd_ready` stays low until a message sends its last beat.
- R11: A doorbell adds `bell_count` to the announced-command count, so one doorbell can launch several commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bell_valid | input | 1 | Doorbell strobe |
| bell_count | input | CNT_W | Number of commands announced by the doorbell |
| cmd_valid | input | 1 | Command queue has an entry |
| cmd_ready | output | 1 | Block takes the queue head this cycle |
| cmd_src | input | ADDR_W | Command source address |
| cmd_dst | input | ADDR_W | Command destination address |
| cmd_len | input | LEN_W | Command length in bytes |
| cmd_ntf_init | input | 1 | Request initiator notification |
| cmd_ntf_rem | input | 1 | Request remote notification |
| pkt_valid | output | 1 | Packet descriptor valid |
| pkt_ready | input | 1 | Downstream accepts the descriptor |
| pkt_slot | output | SLOT_W | Message slot the packet came from |
| pkt_src | output | ADDR_W | Payload source address |
| pkt_dst | output | ADDR_W | Payload destination address |
| pkt_bytes | output | BYTES_W | Payload bytes in this packet |
| pkt_flits | output | FLITS_W | Flits in this packet, header included |
| pkt_last | output | 1 | Final beat of the message |
| pkt_ntf_init | output | 1 | Initiator notification request |
| pkt_ntf_rem | output | 1 | Remote notification request |

## Verification
A slot whose remaining length or address goes wrong shows up on the next beat cut from that slot. The round-robin order bounds this to no more than four beats later, as a wrong `pkt_dst`, `pkt_bytes` or `pkt_flits`, or as a `pkt_last` that comes too early or too late. A wrong rotation pointer shows at once as a wrong `pkt_slot`. A wrong command count shows in the same cycle as `cmd_ready` mismatching. The bench keeps a behavioural model of the queue, the count and the slots, and compares every output on every clock. Any of these faults is therefore reported in the cycle it first becomes visible at the ports.

// File: rtl/rdma_seg_pkg.sv
// Shared defaults for the RDMA write segmenter.
// Assumes: all sizes are powers of two where shifts are used.
package rdma_seg_pkg;
    localparam int DEF_NSLOT      = 4;
    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_LEN_W      = 16;
    localparam int DEF_CNT_W      = 8;
    localparam int DEF_MAX_PKT    = 2048;
    localparam int DEF_FLIT_BYTES = 128;
endpackage

// File: rtl/rdma_seg_pending.sv
// Counts commands announced by doorbells and not yet fetched.
// Assumes: software never announces more commands than the counter holds.
module rdma_seg_pending #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bell_valid,
    input  logic [CNT_W-1:0] bell_count,
    input  logic             take,
    output logic             pend_nz
);
    logic [CNT_W-1:0] pend_q;
    logic [CNT_W-1:0] add_v;

    // Amount added by the doorbell this cycle.
    always_comb add_v = bell_valid ? bell_count : '0;

    // Count update: doorbell adds, fetch removes one.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_q + add_v - CNT_W'(take);
    end

    assign pend_nz = (pend_q != '0);

    // R2
    take_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pend_q != '0);
    // R11
    bell_adds_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bell_valid && !take) |=> pend_q == $past(pend_q) + $past(bell_count));
endmodule

// File: rtl/rdma_seg_arbiter.sv
// Round-robin choice among active message slots, one packet per turn.
// Assumes: advance is only asserted when any is high.
module rdma_seg_arbiter #(
    parameter  int NSLOT  = 4,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSLOT-1:0]  req,
    input  logic              advance,
    output logic [SLOT_W-1:0] grant_idx,
    output logic              any
);
    logic [SLOT_W-1:0] last_q;

    // Search from the slot after the one served last; nearest wins.
    always_comb begin
        any       = 1'b0;
        grant_idx = '0;
        for (int k = NSLOT; k >= 1; k--) begin
            int j;
            j = (int'(last_q) + k) % NSLOT;
            if (req[j]) begin
                any       = 1'b1;
                grant_idx = SLOT_W'(j);
            end
        end
    end

    // Remember the slot that was served.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_q <= SLOT_W'(NSLOT - 1);
        else if (advance) last_q <= grant_idx;
    end

    // R6
    grant_is_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req[grant_idx]);
endmodule

// File: rtl/rdma_seg_slots.sv
// Table of in-flight messages: load into lowest free slot, advance one slot per packet.
// Assumes: load and advance never target the same slot (load uses free slots only).
module rdma_seg_slots #(
    parameter  int NSLOT   = 4,
    parameter  int ADDR_W  = 32,
    parameter  int LEN_W   = 16,
    parameter  int BYTES_W = 12,
    localparam int SLOT_W  = $clog2(NSLOT)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_en,
    input  logic [ADDR_W-1:0]             load_src,
    input  logic [ADDR_W-1:0]             load_dst,
    input  logic [LEN_W-1:0]              load_len,
    input  logic                          load_ni,
    input  logic                          load_nr,
    input  logic                          adv_en,
    input  logic [SLOT_W-1:0]             adv_idx,
    input  logic [BYTES_W-1:0]            adv_bytes,
    input  logic                          adv_last,
    output logic [NSLOT-1:0]              valid,
    output logic [NSLOT-1:0][ADDR_W-1:0]  src,
    output logic [NSLOT-1:0][ADDR_W-1:0]  dst,
    output logic [NSLOT-1:0][LEN_W-1:0]   rem,
    output logic [NSLOT-1:0]              ni,
    output logic [NSLOT-1:0]              nr,
    output logic                          has_free
);
    logic [SLOT_W-1:0] free_idx;

    // Lowest-numbered free slot.
    always_comb begin
        free_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--)
            if (!valid[i]) free_idx = SLOT_W'(i);
    end

    assign has_free = ~&valid;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic hit_load, hit_adv;
        assign hit_load = load_en && (free_idx == SLOT_W'(g));
        assign hit_adv  = adv_en  && (adv_idx  == SLOT_W'(g));

        // Per-slot state: filled by a command, stepped by each packet.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[g] <= 1'b0;
                src[g]   <= '0;
                dst[g]   <= '0;
                rem[g]   <= '0;
                ni[g]    <= 1'b0;
                nr[g]    <= 1'b0;
            end else if (hit_load) begin
                valid[g] <= 1'b1;
                src[g]   <= load_src;
                dst[g]   <= load_dst;
                rem[g]   <= load_len;
                ni[g]    <= load_ni;
                nr[g]    <= load_nr;
            end else if (hit_adv) begin
                src[g]   <= src[g] + ADDR_W'(adv_bytes);
                dst[g]   <= dst[g] + ADDR_W'(adv_bytes);
                rem[g]   <= rem[g] - LEN_W'(adv_bytes);
                if (adv_last) valid[g] <= 1'b0;
            end
        end
    end

    // R10
    load_into_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> !valid[free_idx]);
    // R6
    adv_active_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |-> valid[adv_idx]);
endmodule

// File: rtl/rdma_seg_pktgen.sv
// Sizes the next packet of the chosen message and holds it in the output register.
// Assumes: LEN_W >= BYTES_W; FLIT_BYTES is a power of two.
module rdma_seg_pktgen #(
    parameter  int NSLOT      = 4,
    parameter  int ADDR_W     = 32,
    parameter  int LEN_W      = 16,
    parameter  int MAX_PKT    = 2048,
    parameter  int FLIT_BYTES = 128,
    localparam int SLOT_W     = $clog2(NSLOT),
    localparam int BYTES_W    = $clog2(MAX_PKT + 1),
    localparam int FLITS_W    = $clog2(MAX_PKT / FLIT_BYTES + 2),
    localparam int FLIT_SH    = $clog2(FLIT_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any,
    input  logic [SLOT_W-1:0]  sel_idx,
    input  logic [ADDR_W-1:0]  sel_src,
    input  logic [ADDR_W-1:0]  sel_dst,
    input  logic [LEN_W-1:0]   sel_rem,
    input  logic               sel_ni,
    input  logic               sel_nr,
    output logic               go,
    output logic [BYTES_W-1:0] pay_bytes,
    output logic               pay_last,
    output logic               pkt_valid,
    input  logic               pkt_ready,
    output logic [SLOT_W-1:0]  pkt_slot,
    output logic [ADDR_W-1:0]  pkt_src,
    output logic [ADDR_W-1:0]  pkt_dst,
    output logic [BYTES_W-1:0] pkt_bytes,
    output logic [FLITS_W-1:0] pkt_flits,
    output logic               pkt_last,
    output logic               pkt_ntf_init,
    output logic               pkt_ntf_rem
);
    logic               big;
    logic [BYTES_W:0]   round_up;
    logic [FLITS_W-1:0] pay_flits;

    // Payload size is capped at one maximum packet.
    always_comb begin
        big       = sel_rem > LEN_W'(MAX_PKT);
        pay_bytes = big ? BYTES_W'(MAX_PKT) : sel_rem[BYTES_W-1:0];
        pay_last  = !big;
    end

    // Flit count: payload flits rounded up plus one header flit.
    always_comb begin
        round_up  = {1'b0, pay_bytes} + (BYTES_W + 1)'(FLIT_BYTES - 1);
        pay_flits = (pay_bytes == '0) ? '0 : FLITS_W'(round_up >> FLIT_SH) + FLITS_W'(1);
    end

    assign go = any && (!pkt_valid || pkt_ready);

    // Output register: load a new packet or retire the accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_valid    <= 1'b0;
            pkt_slot     <= '0;
            pkt_src      <= '0;
            pkt_dst      <= '0;
            pkt_bytes    <= '0;
            pkt_flits    <= '0;
            pkt_last     <= 1'b0;
            pkt_ntf_init <= 1'b0;
            pkt_ntf_rem  <= 1'b0;
        end else if (go) begin
            pkt_valid    <= 1'b1;
            pkt_slot     <= sel_idx;
            pkt_src      <= sel_src;
            pkt_dst      <= sel_dst;
            pkt_bytes    <= pay_bytes;
            pkt_flits    <= pay_flits;
            pkt_last     <= pay_last;
            pkt_ntf_init <= pay_last && sel_ni;
            pkt_ntf_rem  <= pay_last && sel_nr;
        end else if (pkt_ready) begin
            pkt_valid    <= 1'b0;
        end
    end

    // R9
    hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> pkt_valid && $stable(pkt_dst) && $stable(pkt_bytes)
            && $stable(pkt_flits) && $stable(pkt_slot) && $stable(pkt_last));
    // R3
    mid_packet_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_last) |-> pkt_bytes == BYTES_W'(MAX_PKT));
    // R7
    notify_on_last_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_last) |-> !pkt_ntf_init && !pkt_ntf_rem);
    // R8
    empty_beat_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_flits == '0) |-> pkt_bytes == '0 && pkt_last);
    // R4
    flit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> pkt_flits <= FLITS_W'(MAX_PKT / FLIT_BYTES + 1));
endmodule

// File: rtl/rdma_seg_top.sv
// RDMA write segmenter: fetches doorbell-announced commands into a slot table
// and emits one packet descriptor per turn, round-robin across active messages.
// Assumes: command fields are valid whenever cmd_valid is high.
module rdma_seg_top
    import rdma_seg_pkg::*;
#(
    parameter  int NSLOT      = DEF_NSLOT,
    parameter  int ADDR_W     = DEF_ADDR_W,
    parameter  int LEN_W      = DEF_LEN_W,
    parameter  int CNT_W      = DEF_CNT_W,
    parameter  int MAX_PKT    = DEF_MAX_PKT,
    parameter  int FLIT_BYTES = DEF_FLIT_BYTES,
    localparam int SLOT_W     = $clog2(NSLOT),
    localparam int BYTES_W    = $clog2(MAX_PKT + 1),
    localparam int FLITS_W    = $clog2(MAX_PKT / FLIT_BYTES + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bell_valid,
    input  logic [CNT_W-1:0]   bell_count,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [ADDR_W-1:0]  cmd_src,
    input  logic [ADDR_W-1:0]  cmd_dst,
    input  logic [LEN_W-1:0]   cmd_len,
    input  logic               cmd_ntf_init,
    input  logic               cmd_ntf_rem,
    output logic               pkt_valid,
    input  logic               pkt_ready,
    output logic [SLOT_W-1:0]  pkt_slot,
    output logic [ADDR_W-1:0]  pkt_src,
    output logic [ADDR_W-1:0]  pkt_dst,
    output logic [BYTES_W-1:0] pkt_bytes,
    output logic [FLITS_W-1:0] pkt_flits,
    output logic               pkt_last,
    output logic               pkt_ntf_init,
    output logic               pkt_ntf_rem
);
    logic                         pend_nz, has_free, take, any, go, pay_last;
    logic [SLOT_W-1:0]            grant_idx;
    logic [BYTES_W-1:0]           pay_bytes;
    logic [NSLOT-1:0]             s_valid, s_ni, s_nr;
    logic [NSLOT-1:0][ADDR_W-1:0] s_src, s_dst;
    logic [NSLOT-1:0][LEN_W-1:0]  s_rem;

    assign cmd_ready = pend_nz && has_free;
    assign take      = cmd_valid && cmd_ready;

    rdma_seg_pending #(.CNT_W(CNT_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .bell_valid(bell_valid),
        .bell_count(bell_count), .take(take), .pend_nz(pend_nz)
    );

    rdma_seg_slots #(.NSLOT(NSLOT), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTES_W(BYTES_W)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .load_en(take), .load_src(cmd_src), .load_dst(cmd_dst), .load_len(cmd_len),
        .load_ni(cmd_ntf_init), .load_nr(cmd_ntf_rem),
        .adv_en(go), .adv_idx(grant_idx), .adv_bytes(pay_bytes), .adv_last(pay_last),
        .valid(s_valid), .src(s_src), .dst(s_dst), .rem(s_rem), .ni(s_ni), .nr(s_nr),
        .has_free(has_free)
    );

    rdma_seg_arbiter #(.NSLOT(NSLOT)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(s_valid), .advance(go),
        .grant_idx(grant_idx), .any(any)
    );

    rdma_seg_pktgen #(.NSLOT(NSLOT), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
                      .MAX_PKT(MAX_PKT), .FLIT_BYTES(FLIT_BYTES)) u_gen (
        .clk(clk), .rst_n(rst_n), .any(any), .sel_idx(grant_idx),
        .sel_src(s_src[grant_idx]), .sel_dst(s_dst[grant_idx]), .sel_rem(s_rem[grant_idx]),
        .sel_ni(s_ni[grant_idx]), .sel_nr(s_nr[grant_idx]),
        .go(go), .pay_bytes(pay_bytes), .pay_last(pay_last),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_slot(pkt_slot),
        .pkt_src(pkt_src), .pkt_dst(pkt_dst), .pkt_bytes(pkt_bytes), .pkt_flits(pkt_flits),
        .pkt_last(pkt_last), .pkt_ntf_init(pkt_ntf_init), .pkt_ntf_rem(pkt_ntf_rem)
    );

    // R10
    full_blocks_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&s_valid) |-> !cmd_ready);
endmodule

// File: tb/rdma_seg_top_tb.sv
// Bench: behavioural model of doorbell count, command queue and message slots,
// compared against every output on every clock.
module rdma_seg_top_tb;
    localparam int NS = 4;
    localparam int MAXP = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bell_valid = 1'b0;
    logic [7:0]  bell_count = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_src = '0, cmd_dst = '0;
    logic [15:0] cmd_len = '0;
    logic        cmd_ntf_init = 1'b0, cmd_ntf_rem = 1'b0;
    logic        pkt_valid, pkt_ready = 1'b1;
    logic [1:0]  pkt_slot;
    logic [31:0] pkt_src, pkt_dst;
    logic [11:0] pkt_bytes;
    logic [4:0]  pkt_flits;
    logic        pkt_last, pkt_ntf_init, pkt_ntf_rem;

    always #10 clk = ~clk;

    rdma_seg_top u_dut (
        .clk(clk), .rst_n(rst_n), .bell_valid(bell_valid), .bell_count(bell_count),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
        .cmd_len(cmd_len), .cmd_ntf_init(cmd_ntf_init), .cmd_ntf_rem(cmd_ntf_rem),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_slot(pkt_slot),
        .pkt_src(pkt_src), .pkt_dst(pkt_dst), .pkt_bytes(pkt_bytes), .pkt_flits(pkt_flits),
        .pkt_last(pkt_last), .pkt_ntf_init(pkt_ntf_init), .pkt_ntf_rem(pkt_ntf_rem)
    );

    typedef struct { longint src; longint dst; int len; bit ni; bit nr; } cmd_t;
    cmd_t q[$];

    int  n_checks = 0, n_fail = 0, cycles = 0;
    bit  ready_jitter = 0;
    logic [7:0] lfsr = 8'h5a;

    // Model state.
    bit     m_act[NS];
    longint m_src[NS], m_dst[NS];
    int     m_rem[NS];
    bit     m_ni[NS], m_nr[NS];
    int     m_pend, m_rr;
    bit     o_v, o_last, o_ni, o_nr;
    int     o_slot, o_bytes, o_flits;
    longint o_src, o_dst;

    // Model update on every edge, from bench-driven inputs only.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) m_act[i] = 0;
            m_pend = 0; m_rr = NS - 1; o_v = 0;
        end else begin
            bit fr[NS];
            bit anyfree;
            for (int i = 0; i < NS; i++) fr[i] = !m_act[i];
            if (!o_v || pkt_ready) begin
                int pick;
                pick = -1;
                for (int k = 1; k <= NS; k++)
                    if (pick < 0 && m_act[(m_rr + k) % NS]) pick = (m_rr + k) % NS;
                if (pick >= 0) begin
                    int b;
                    b = (m_rem[pick] > MAXP) ? MAXP : m_rem[pick];
                    o_v = 1; o_slot = pick; o_src = m_src[pick]; o_dst = m_dst[pick];
                    o_bytes = b; o_flits = (b == 0) ? 0 : (b + 127) / 128 + 1;
                    o_last = (m_rem[pick] <= MAXP);
                    o_ni = o_last && m_ni[pick]; o_nr = o_last && m_nr[pick];
                    m_src[pick] = (m_src[pick] + b) & 64'hffff_ffff;
                    m_dst[pick] = (m_dst[pick] + b) & 64'hffff_ffff;
                    m_rem[pick] -= b;
                    if (o_last) m_act[pick] = 0;
                    m_rr = pick;
                end else o_v = 0;
            end
            anyfree = 0;
            for (int i = 0; i < NS; i++) if (fr[i]) anyfree = 1;
            if (m_pend != 0 && cmd_valid && anyfree) begin
                int f;
                f = -1;
                for (int i = 0; i < NS; i++) if (f < 0 && fr[i]) f = i;
                m_act[f] = 1; m_src[f] = q[0].src; m_dst[f] = q[0].dst; m_rem[f] = q[0].len;
                m_ni[f] = q[0].ni; m_nr[f] = q[0].nr;
                void'(q.pop_front());
                m_pend--;
            end
            if (bell_valid) m_pend += bell_count;
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic bit model_ready();
        bit f;
        f = 0;
        for (int i = 0; i < NS; i++) if (!m_act[i]) f = 1;
        return (m_pend != 0) && f;
    endfunction

    // Compare every output against the model.
    task automatic compare();
        chk("R2/R10 cmd_ready", cmd_ready, model_ready());
        chk("R6 pkt_valid", pkt_valid, o_v);
        if (o_v) begin
            chk("R6 pkt_slot", pkt_slot, o_slot);
            chk("R5 pkt_src", pkt_src, o_src);
            chk("R5 pkt_dst", pkt_dst, o_dst);
            chk("R3 pkt_bytes", pkt_bytes, o_bytes);
            chk("R4 pkt_flits", pkt_flits, o_flits);
            chk("R8 pkt_last", pkt_last, o_last);
            chk("R7 pkt_ntf_init", pkt_ntf_init, o_ni);
            chk("R7 pkt_ntf_rem", pkt_ntf_rem, o_nr);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // One clock: drive inputs, let the edge pass, compare at the falling edge.
    task automatic step();
        cmd_valid = (q.size() != 0);
        if (q.size() != 0) begin
            cmd_src = q[0].src[31:0]; cmd_dst = q[0].dst[31:0]; cmd_len = 16'(q[0].len);
            cmd_ntf_init = q[0].ni; cmd_ntf_rem = q[0].nr;
        end
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        pkt_ready = ready_jitter ? lfsr[0] : 1'b1;
        @(posedge clk);
        @(negedge clk);
        bell_valid = 1'b0;
        cycles++;
        if (cycles > 20000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
        compare();
    endtask

    task automatic push(longint s, longint d, int len, bit ni, bit nr);
        cmd_t c;
        c.src = s; c.dst = d; c.len = len; c.ni = ni; c.nr = nr;
        q.push_back(c);
    endtask

    task automatic ring(int n);
        bell_valid = 1'b1; bell_count = 8'(n);
        step();
    endtask

    task automatic drain();
        for (int i = 0; i < 400; i++) begin
            bit busy;
            busy = o_v || q.size() != 0;
            for (int s = 0; s < NS; s++) if (m_act[s]) busy = 1;
            if (!busy) break;
            step();
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pkt_valid", pkt_valid, 0);
        chk("R1 cmd_ready", cmd_ready, 0);
        rst_n = 1'b1;
        step();
        chk("R1 idle cmd_ready", cmd_ready, 0);

        // R2: queued commands are not taken while no doorbell count exists
        push(32'h1000, 32'h8000_0000, 300, 1, 0);
        push(32'h2000, 32'h9000_0000, 5000, 1, 1);
        for (int i = 0; i < 6; i++) step();
        chk("R2 queue untouched", q.size(), 2);

        // R11: one doorbell launches both, plus long/short interleave (R3, R5, R6)
        ring(2);
        drain();

        // R3/R4 boundaries and R8 zero length, in one doorbell
        push(32'h100, 32'h200, 2048, 0, 1);
        push(32'h300, 32'h400, 128, 1, 1);
        push(32'h500, 32'h600, 0, 1, 1);
        push(32'h700, 32'h800, 1, 0, 0);
        push(32'h900, 32'ha00, 129, 1, 0);
        push(32'hb00, 32'hc00, 4096, 0, 1);
        ring(6);
        drain();

        // R10: six long messages, only four active; R9 under jittered ready
        ready_jitter = 1;
        for (int i = 0; i < 6; i++) push(64'h1_0000 * i, 64'h10_0000 * i, 2049 + 700 * i, i[0], !i[0]);
        ring(3);
        step();
        ring(3);
        drain();

        // Address wrap and two doorbells before fetch (R11)
        push(32'hffff_fc00, 32'hffff_ff00, 3000, 1, 1);
        push(32'h0, 32'h0, 0, 0, 0);
        bell_valid = 1'b1; bell_count = 8'd1;
        step();
        ring(1);
        drain();
        ready_jitter = 0;
        drain();

        finish_run();
    end
endmodule